// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Status Flags

This block is the execution datapath of a small processor core. It combines an 8-bit arithmetic logic unit with an 8-bit status register. The second operand is either a register value or an immediate, chosen per operation. The result is combinational, so it is valid in the same cycle the operands and operation code are presented. When the operation is marked valid, the status register takes the new flag values on the next rising clock edge.

The operations fall into three groups:
- **Arithmetic:** add and subtract, each with or without the stored carry.
- **Logical:** AND, OR, XOR.
- **Bit:** store an operand bit into the T flag, load T into a result bit, and set or clear the interrupt-enable bit.

A direct write port lets software-visible code load the whole status register. That write takes priority over any flag update issued in the same cycle. The register holds no state machine. Its two transitions per cycle are *write* (direct port) and *update* (valid operation); with neither, it holds.

Top module: `alu_sreg_top`

## Requirements
- R1: After reset the status register reads 0x00. Its bit layout from bit 7 down to bit 0 is I (interrupt enable), T (bit store), H (half carry), S (sign), V (overflow), N (negative), Z (zero), C (carry).
- R2: Operation codes 0 (ADD) and 1 (ADC, which adds the stored C) produce `opa + operand` modulo 256. C is the carry out of bit 7. H is the carry out of bit 3. V is set when both operands share a sign and the result's sign differs from it.
- R3: Operation codes 2 (SUB) and 3 (SBC, which also subtracts the stored C) produce `opa - operand` modulo 256. C is the borrow out of bit 7. H is the borrow out of bit 3. V is set when the operand signs differ and the result's sign differs from the sign of `opa`.
- R4: For arithmetic and logical operations, N equals result bit 7, and Z is set exactly when the 8-bit result is zero.
- R5: S equals N XOR V at every clock edge, including after a direct write. The S bit of the write data is ignored and recomputed from the written N and V.
- R6: Operation codes 4 (AND), 5 (OR) and 6 (XOR) clear V and leave C and H unchanged.
- R7: When `use_imm` is 1, `imm` replaces `opb` as the second operand.
- R8: Operation code 7 (BST) copies `opa[bit_sel]` into T. The result equals `opa`, and all other flags are unchanged.
- R9: Operation code 8 (BLD) returns `opa` with bit `bit_sel` replaced by T. All flags are unchanged.
- R10: Operation code 9 sets I and code 10 clears I. No other flag changes.
- R11: A direct write (`sr_we`) loads the status register on the next edge, overriding an operation presented in the same cycle.
- R12: The result follows the inputs within the same cycle. When neither `op_valid` nor `sr_we` is high, the status register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Commit the flag update of the presented operation |
| op_code | input | 4 | Operation code (see R2 to R10) |
| opa | input | 8 | First register operand |
| opb | input | 8 | Second register operand |
| imm | input | 8 | Immediate operand |
| use_imm | input | 1 | Select `imm` as the second operand |
| bit_sel | input | 3 | Bit index for BST and BLD |
| sr_we | input | 1 | Direct status register write |
| sr_wdata | input | 8 | Direct write data |
| result | output | 8 | Operation result |
| status | output | 8 | Status register contents |

## Verification
The assertions assume that `op_code`, `opa`, `opb`, `bit_sel` and the select lines are steady across each rising edge. They also assume that an operation's result is judged against the status value present in the same cycle. The stimulus meets both conditions: every input changes only on the falling edge. Each table vector first preloads the status register through the write port and then applies the operation with the write port idle. Only the priority test drives a write and a valid operation together.

// File: rtl/alu_sreg_pkg.sv
package alu_sreg_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_BST  = 4'd7,
        OP_BLD  = 4'd8,
        OP_SETI = 4'd9,
        OP_CLRI = 4'd10
    } alu_op_e;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;
    localparam int SR_W = 8;

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_sreg_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NIB   = 4,
    localparam int BSW  = $clog2(DW)
) (
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic [BSW-1:0]   bsel,
    input  logic [SR_W-1:0]  st,
    output logic [DW-1:0]    res,
    output logic [SR_W-1:0]  st_nxt
);

    logic            cin;
    logic [DW:0]     add_full;
    logic [DW:0]     sub_full;
    logic [NIB:0]    nib_add;
    logic [NIB:0]    nib_sub;
    logic            upd_nz;

    assign cin      = ((op == OP_ADC) || (op == OP_SBC)) ? st[FL_C] : 1'b0;
    assign add_full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    assign sub_full = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
    assign nib_add  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    assign nib_sub  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};

    always_comb begin
        res    = a;
        st_nxt = st;
        upd_nz = 1'b0;
        case (op)
            OP_ADD, OP_ADC: begin
                res          = add_full[DW-1:0];
                st_nxt[FL_C] = add_full[DW];
                st_nxt[FL_H] = nib_add[NIB];
                st_nxt[FL_V] = (a[DW-1] == b[DW-1]) && (add_full[DW-1] != a[DW-1]);
                upd_nz       = 1'b1;
            end
            OP_SUB, OP_SBC: begin
                res          = sub_full[DW-1:0];
                st_nxt[FL_C] = sub_full[DW];
                st_nxt[FL_H] = nib_sub[NIB];
                st_nxt[FL_V] = (a[DW-1] != b[DW-1]) && (sub_full[DW-1] != a[DW-1]);
                upd_nz       = 1'b1;
            end
            OP_AND: begin
                res          = a & b;
                st_nxt[FL_V] = 1'b0;
                upd_nz       = 1'b1;
            end
            OP_OR: begin
                res          = a | b;
                st_nxt[FL_V] = 1'b0;
                upd_nz       = 1'b1;
            end
            OP_XOR: begin
                res          = a ^ b;
                st_nxt[FL_V] = 1'b0;
                upd_nz       = 1'b1;
            end
            OP_BST:  st_nxt[FL_T] = a[bsel];
            OP_BLD:  res[bsel]    = st[FL_T];
            OP_SETI: st_nxt[FL_I] = 1'b1;
            OP_CLRI: st_nxt[FL_I] = 1'b0;
            default: ;
        endcase
        if (upd_nz) begin
            st_nxt[FL_N] = res[DW-1];
            st_nxt[FL_Z] = (res == '0);
            st_nxt[FL_S] = res[DW-1] ^ st_nxt[FL_V];
        end
    end

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
    import alu_sreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [SR_W-1:0]  upd_val,
    input  logic             wr_en,
    input  logic [SR_W-1:0]  wr_val,
    output logic [SR_W-1:0]  sr_q
);

    logic [SR_W-1:0] wr_fixed;

    always_comb begin
        wr_fixed       = wr_val;
        wr_fixed[FL_S] = wr_val[FL_N] ^ wr_val[FL_V];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sr_q <= '0;
        else if (wr_en)  sr_q <= wr_fixed;
        else if (upd_en) sr_q <= upd_val;
    end

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (sr_q[7:5] == $past(wr_val[7:5])) && (sr_q[3:0] == $past(wr_val[3:0])));

    a_r5_sign_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q[FL_S] == (sr_q[FL_N] ^ sr_q[FL_V]));

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !upd_en) |=> $stable(sr_q));

endmodule

// File: rtl/alu_sreg_top.sv
module alu_sreg_top
    import alu_sreg_pkg::*;
#(
    parameter int DW = 8,
    localparam int BSW = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [3:0]      op_code,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    input  logic [DW-1:0]   imm,
    input  logic            use_imm,
    input  logic [BSW-1:0]  bit_sel,
    input  logic            sr_we,
    input  logic [7:0]      sr_wdata,
    output logic [DW-1:0]   result,
    output logic [7:0]      status
);

    alu_op_e          op;
    logic [DW-1:0]    operand_b;
    logic [SR_W-1:0]  st_nxt;

    assign op        = alu_op_e'(op_code);
    assign operand_b = use_imm ? imm : opb;

    alu_datapath #(.DW(DW)) u_dp (
        .op     (op),
        .a      (opa),
        .b      (operand_b),
        .bsel   (bit_sel),
        .st     (status),
        .res    (result),
        .st_nxt (st_nxt)
    );

    alu_status_reg u_sr (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (op_valid),
        .upd_val (st_nxt),
        .wr_en   (sr_we),
        .wr_val  (sr_wdata),
        .sr_q    (status)
    );

    a_r6_logic_keeps_ch: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sr_we && (op == OP_AND || op == OP_OR || op == OP_XOR))
        |=> !status[FL_V] && (status[FL_C] == $past(status[FL_C]))
            && (status[FL_H] == $past(status[FL_H])));

    a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sr_we && (op_code <= 4'd6))
        |=> status[FL_Z] == ($past(result) == '0));

    a_r9_bld_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BLD) |-> result[bit_sel] == status[FL_T]);

    a_r10_seti: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sr_we && op == OP_SETI) |=> status[FL_I]);

endmodule

// File: tb/alu_sreg_top_tb.sv
`timescale 1ns/1ps
module alu_sreg_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] opa = '0, opb = '0, imm = '0;
    logic       use_imm = 1'b0;
    logic [2:0] bit_sel = '0;
    logic       sr_we = 1'b0;
    logic [7:0] sr_wdata = '0;
    logic [7:0] result, status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    alu_sreg_top u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opa(opa), .opb(opb), .imm(imm), .use_imm(use_imm), .bit_sel(bit_sel),
        .sr_we(sr_we), .sr_wdata(sr_wdata), .result(result), .status(status)
    );

    // {op, a, b (bit index in [2:0] for BST/BLD), preset status, exp result, exp status}
    localparam logic [43:0] VEC [16] = '{
        {4'h0, 8'h3A, 8'h29, 8'h00, 8'h63, 8'h20},
        {4'h0, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h2C},
        {4'h0, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h23},
        {4'h1, 8'h10, 8'h20, 8'h01, 8'h31, 8'h00},
        {4'h2, 8'h50, 8'h70, 8'h00, 8'hE0, 8'h15},
        {4'h2, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h38},
        {4'h3, 8'h05, 8'h05, 8'h01, 8'hFF, 8'h35},
        {4'h2, 8'h42, 8'h42, 8'h00, 8'h00, 8'h02},
        {4'h4, 8'hF0, 8'h3C, 8'h39, 8'h30, 8'h21},
        {4'h5, 8'h80, 8'h01, 8'h00, 8'h81, 8'h14},
        {4'h6, 8'h5A, 8'h5A, 8'h18, 8'h00, 8'h02},
        {4'h7, 8'h04, 8'h02, 8'h00, 8'h04, 8'h40},
        {4'h8, 8'h00, 8'h07, 8'h40, 8'h80, 8'h40},
        {4'h8, 8'hFF, 8'h00, 8'h00, 8'hFE, 8'h00},
        {4'h9, 8'h11, 8'h00, 8'h03, 8'h11, 8'h83},
        {4'hA, 8'h11, 8'h00, 8'h83, 8'h11, 8'h03}
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'h0, 4'h1:       return "R2";
            4'h2, 4'h3:       return "R3";
            4'h4, 4'h5, 4'h6: return "R6";
            4'h7:             return "R8";
            4'h8:             return "R9";
            default:          return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic preload(input logic [7:0] v);
        @(negedge clk);
        op_valid = 1'b0; sr_we = 1'b1; sr_wdata = v;
        @(posedge clk); #1;
        @(negedge clk);
        sr_we = 1'b0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "status after reset", status, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < 16; i++) begin
            logic [43:0] v;
            v = VEC[i];
            preload(v[23:16]);
            op_code = v[43:40]; opa = v[39:32]; opb = v[31:24];
            bit_sel = v[26:24]; use_imm = 1'b0; op_valid = 1'b1;
            #1;
            check(req_of(v[43:40]), "result", result, v[15:8]);
            @(posedge clk); #1;
            check(req_of(v[43:40]), "status (R4 N/Z, R5 S)", status, v[7:0]);
            @(negedge clk); op_valid = 1'b0;
        end

        // R7: immediate replaces opb
        preload(8'h00);
        op_code = 4'h0; opa = 8'h01; opb = 8'hF0; imm = 8'h02; use_imm = 1'b1; op_valid = 1'b1;
        #1;
        check("R7", "immediate add result", result, 8'h03);
        @(posedge clk); #1;
        check("R7", "immediate add status", status, 8'h00);
        @(negedge clk); op_valid = 1'b0; use_imm = 1'b0;

        // R5: written S bit ignored, recomputed from N and V
        preload(8'h10);
        #1;
        check("R5", "S recomputed on write", status, 8'h00);
        preload(8'h0C);
        #1;
        check("R5", "S with N and V set", status, 8'h0C);

        // R11: write beats simultaneous operation
        preload(8'h00);
        op_code = 4'h0; opa = 8'hFF; opb = 8'h01; op_valid = 1'b1;
        sr_we = 1'b1; sr_wdata = 8'h05;
        @(posedge clk); #1;
        check("R11", "write priority", status, 8'h15);
        @(negedge clk); sr_we = 1'b0; op_valid = 1'b0;

        // R12: result combinational, status held without valid
        preload(8'h23);
        op_code = 4'h2; opa = 8'h10; opb = 8'h20; op_valid = 1'b0;
        #1;
        check("R12", "result without valid", result, 8'hF0);
        @(posedge clk); #1;
        check("R12", "status held", status, 8'h23);

        // R1: reset clears a populated register
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R1", "status after second reset", status, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule